// File: doc/BRIEF.md
# Multi-mode timer / event counter

An up-counter with a parameterised width and three counting modes. In free-running timer mode it advances once per clock. In event mode it advances once per selected transition on an asynchronous external pin. In gated mode it advances on every clock during which the external pin holds the selected level. A host register port reaches the mode, enable and polarity controls, the reload value, the live count and the request flag.

When the counter rolls past all ones it reloads from the reload register and sets a sticky request flag. The flag drives the interrupt output through an enable bit. Separately, a one-cycle wake pulse is raised at each rollover that finds the flag clear. Software can therefore suppress wake-ups by setting the flag before it sleeps. A counter read and a reload write each stall counting for the cycle of the access.

Top module: `evt_timer`

## Requirements
- R1: After reset the control register reads 0 (disabled, mode 0), the request flag reads 0, and `irq_o` and `wake_o` are low.
- R2: Control register (address 0) fields: bits[1:0] mode, bit2 polarity, bit3 enable, bit4 interrupt enable. With mode 1 (timer) and enable set, the count rises by one every clock. With enable clear, the count holds.
- R3: With mode 2 (event), the pin passes through a two-flop synchroniser. The count rises once per rising edge when polarity is 0, and once per falling edge when polarity is 1.
- R4: With mode 3 (gated), the count rises on every clock in which the synchronised pin is high (polarity 0) or low (polarity 1).
- R5: Reading the counter (address 2 with `bus_rd_i`) or writing the reload register (address 1) blocks counting for that clock.
- R6: A count step taken at all ones loads the reload value instead and sets the request flag (address 3, bit 0).
- R7: `irq_o` is high exactly while the request flag and the interrupt enable bit are both set.
- R8: A rollover that finds the flag clear raises `wake_o` for one clock, in the cycle after the rollover, whatever the interrupt enable. A rollover that finds the flag already set raises no wake pulse.
- R9: Writing address 3 sets the flag to bit 0 of the data. If a rollover coincides with a write of 0, the flag ends up set.
- R10: A reload write while enable is clear also loads the counter. While enable is set it updates only the reload register.
- R11: Mode 0 never counts, even with enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register address: 0 control, 1 reload, 2 counter, 3 flag |
| bus_wdata_i | input | W | Write data |
| bus_rdata_o | output | W | Read data, combinational from the address |
| ext_pin_i | input | 1 | Asynchronous external count/gate pin |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-up pulse |

## Verification
The bench counts exact numbers of steps across enable windows that contain counter reads. A design that ignored the access stall would come out several counts high, and one that stalled on every read would miss steps. Rollover is tested twice. The first time the flag is clear, so exactly one wake pulse must appear. The second time the flag is set, and a design that gated wake with the interrupt enable, or ignored the prior flag, would show a missing or an extra pulse. A clear that lands on the same edge as a rollover must leave the flag set. Polarity is exercised in both event and gated modes, where a swapped edge or level would give a count off by the pulse lengths.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 2'd0,
    A_PRE   = 2'd1,
    A_CNT   = 2'd2,
    A_FLAG  = 2'd3
  } tmr_addr_e;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_TIMER = 2'd1,
    MODE_EVENT = 2'd2,
    MODE_GATED = 2'd3
  } tmr_mode_e;

  localparam int CTRL_BITS = 5;
  localparam int B_POL = 2;
  localparam int B_EN  = 3;
  localparam int B_IE  = 4;

  typedef struct packed {
    logic      ie;
    logic      en;
    logic      pol;
    tmr_mode_e mode;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_pin_cond.sv
module tmr_pin_cond #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic pin_i,
  input  logic pol_i,
  output logic edge_o,
  output logic level_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              pin_s;
  logic              rise_w;
  logic              fall_w;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_n_i) begin
          if (!rst_n_i) sync_q[0] <= 1'b0;
          else          sync_q[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_n_i) begin
          if (!rst_n_i) sync_q[g] <= 1'b0;
          else          sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign pin_s = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) prev_q <= 1'b0;
    else          prev_q <= pin_s;
  end

  assign rise_w  = pin_s & ~prev_q;
  assign fall_w  = ~pin_s & prev_q;
  assign edge_o  = pol_i ? fall_w : rise_w;
  assign level_o = pol_i ? ~pin_s : pin_s;
endmodule

// File: rtl/tmr_host_regs.sv
module tmr_host_regs
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      count_i,
  input  logic              flag_i,
  output tmr_ctrl_t         ctrl_o,
  output logic [W-1:0]      preload_o,
  output logic              pre_wr_o,
  output logic              cnt_rd_o,
  output logic              flag_wr_o,
  output logic              flag_val_o
);
  tmr_ctrl_t   ctrl_q;
  logic [W-1:0] pre_q;
  logic        ctrl_wr;

  assign ctrl_wr    = wr_i && (addr_i == A_CTRL);
  assign pre_wr_o   = wr_i && (addr_i == A_PRE);
  assign cnt_rd_o   = rd_i && (addr_i == A_CNT);
  assign flag_wr_o  = wr_i && (addr_i == A_FLAG);
  assign flag_val_o = wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ctrl_q <= '0;
      pre_q  <= '0;
    end else begin
      if (ctrl_wr)  ctrl_q <= tmr_ctrl_t'(wdata_i[CTRL_BITS-1:0]);
      if (pre_wr_o) pre_q  <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: rdata_o[CTRL_BITS-1:0] = ctrl_q;
      A_PRE:  rdata_o = pre_q;
      A_CNT:  rdata_o = count_i;
      A_FLAG: rdata_o[0] = flag_i;
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o    = ctrl_q;
  assign preload_o = pre_q;
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         en_i,
  input  tmr_mode_e    mode_i,
  input  logic         edge_i,
  input  logic         level_i,
  input  logic         inhibit_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] preload_i,
  output logic [W-1:0] count_o,
  output logic         tick_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] FULL = '1;

  function automatic logic wraps(input logic [W-1:0] c);
    return c == FULL;
  endfunction

  function automatic logic [W-1:0] advance(input logic [W-1:0] c,
                                           input logic [W-1:0] pre);
    return wraps(c) ? pre : c + 1'b1;
  endfunction

  logic [W-1:0] cnt_q;
  logic         step_ok;

  always_comb begin
    unique case (mode_i)
      MODE_TIMER: step_ok = 1'b1;
      MODE_EVENT: step_ok = edge_i;
      MODE_GATED: step_ok = level_i;
      default:    step_ok = 1'b0;
    endcase
  end

  assign tick_o = en_i && !inhibit_i && step_ok;
  assign ovf_o  = tick_o && wraps(cnt_q);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_o) cnt_q <= advance(cnt_q, preload_i);
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/tmr_irq_flag.sv
module tmr_irq_flag (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic ovf_i,
  input  logic wr_i,
  input  logic wval_i,
  input  logic ie_i,
  output logic flag_o,
  output logic irq_o,
  output logic wake_o
);
  logic flag_q;
  logic wake_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      flag_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      if (ovf_i)     flag_q <= 1'b1;
      else if (wr_i) flag_q <= wval_i;
      wake_q <= ovf_i && !flag_q;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ie_i;
  assign wake_o = wake_q;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import tmr_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [W-1:0]      bus_wdata_i,
  output logic [W-1:0]      bus_rdata_o,
  input  logic              ext_pin_i,
  output logic              irq_o,
  output logic              wake_o
);
  tmr_ctrl_t    ctrl_w;
  logic [W-1:0] preload_w;
  logic [W-1:0] count_w;
  logic         pre_wr_w;
  logic         cnt_rd_w;
  logic         flag_wr_w;
  logic         flag_val_w;
  logic         flag_w;
  logic         edge_w;
  logic         level_w;
  logic         inhibit_w;
  logic         load_w;
  logic         tick_w;
  logic         ovf_w;

  tmr_host_regs #(.W(W)) u_regs (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .wr_i       (bus_wr_i),
    .rd_i       (bus_rd_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .rdata_o    (bus_rdata_o),
    .count_i    (count_w),
    .flag_i     (flag_w),
    .ctrl_o     (ctrl_w),
    .preload_o  (preload_w),
    .pre_wr_o   (pre_wr_w),
    .cnt_rd_o   (cnt_rd_w),
    .flag_wr_o  (flag_wr_w),
    .flag_val_o (flag_val_w)
  );

  tmr_pin_cond #(.STAGES(SYNC_STAGES)) u_pin (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .pin_i   (ext_pin_i),
    .pol_i   (ctrl_w.pol),
    .edge_o  (edge_w),
    .level_o (level_w)
  );

  assign inhibit_w = cnt_rd_w || pre_wr_w;
  assign load_w    = pre_wr_w && !ctrl_w.en;

  tmr_count_core #(.W(W)) u_core (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .en_i       (ctrl_w.en),
    .mode_i     (ctrl_w.mode),
    .edge_i     (edge_w),
    .level_i    (level_w),
    .inhibit_i  (inhibit_w),
    .load_i     (load_w),
    .load_val_i (bus_wdata_i),
    .preload_i  (preload_w),
    .count_o    (count_w),
    .tick_o     (tick_w),
    .ovf_o      (ovf_w)
  );

  tmr_irq_flag u_flag (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .ovf_i   (ovf_w),
    .wr_i    (flag_wr_w),
    .wval_i  (flag_val_w),
    .ie_i    (ctrl_w.ie),
    .flag_o  (flag_w),
    .irq_o   (irq_o),
    .wake_o  (wake_o)
  );
endmodule

// File: rtl/evt_timer_checker.sv
module evt_timer_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         tick,
  input logic         ovf,
  input logic         inhibit,
  input logic         load,
  input logic [W-1:0] count,
  input logic [W-1:0] preload,
  input logic         flag,
  input logic         wake
);
  assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ovf) |=> count == W'($past(count) + 1'b1));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(count));

  assert_access_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !load) |=> $stable(count));

  assert_wrap_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> count == $past(preload));

  assert_wrap_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> flag);

  assert_wake_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> ($past(ovf) && !$past(flag)));

  assert_wake_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !flag) |=> wake);
endmodule

bind evt_timer evt_timer_checker #(.W(W)) u_chk (
  .clk     (clk_i),
  .rst_n   (rst_n_i),
  .en      (ctrl_w.en),
  .tick    (tick_w),
  .ovf     (ovf_w),
  .inhibit (inhibit_w),
  .load    (load_w),
  .count   (count_w),
  .preload (preload_w),
  .flag    (flag_w),
  .wake    (wake_o)
);

// File: tb/evt_timer_bench.sv
module evt_timer_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr, rd;
  logic [1:0]   addr;
  logic [W-1:0] wdata;
  logic [W-1:0] rdata;
  logic         pin;
  logic         irq, wake;

  int n_checks = 0;
  int n_errors = 0;
  int wake_seen = 0;
  bit done = 0;

  always #10 clk = ~clk;

  evt_timer #(.W(W)) u_evt_timer (
    .clk_i       (clk),
    .rst_n_i     (rst_n),
    .bus_wr_i    (wr),
    .bus_rd_i    (rd),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .ext_pin_i   (pin),
    .irq_o       (irq),
    .wake_o      (wake)
  );

  always @(negedge clk) if (rst_n && wake) wake_seen++;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [W-1:0] d);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_reg(input string req, input logic [1:0] a, input int exp);
    logic [W-1:0] d;
    bus_read(a, d);
    check(req, d, exp);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pin = 1'b1; idle(4);
      pin = 1'b0; idle(4);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pin = 1'b0; wr = 0; rd = 0; addr = 0; wdata = 0;
    idle(3);
    check("R1 irq at reset", irq, 0);
    check("R1 wake at reset", wake, 0);
    rst_n = 1'b1;
    idle(1);
    expect_reg("R1 control", 2'd0, 0);
    expect_reg("R1 flag", 2'd3, 0);
  endtask

  task automatic t_timer();
    bus_write(2'd1, 8'h20);
    expect_reg("R10 disabled reload loads counter", 2'd2, 8'h20);
    bus_write(2'd0, 8'h09);
    idle(9);
    bus_write(2'd0, 8'h00);
    expect_reg("R2 timer ten steps", 2'd2, 8'h2A);
    idle(3);
    expect_reg("R2 disabled holds", 2'd2, 8'h2A);
  endtask

  task automatic t_mode_zero();
    bus_write(2'd0, 8'h08);
    idle(5);
    bus_write(2'd0, 8'h00);
    expect_reg("R11 mode 0 no count", 2'd2, 8'h2A);
  endtask

  task automatic t_inhibit();
    logic [W-1:0] d;
    bus_write(2'd1, 8'h10);
    bus_write(2'd0, 8'h09);
    idle(3);
    for (int i = 0; i < 4; i++) bus_read(2'd2, d);
    idle(2);
    bus_write(2'd0, 8'h00);
    expect_reg("R5 counter reads stall", 2'd2, 8'h16);
  endtask

  task automatic t_reload_enabled();
    bus_write(2'd1, 8'h30);
    bus_write(2'd0, 8'h09);
    bus_write(2'd1, 8'h40);
    bus_write(2'd0, 8'h00);
    expect_reg("R10 R5 enabled reload write", 2'd2, 8'h31);
    expect_reg("R10 reload value", 2'd1, 8'h40);
  endtask

  task automatic t_event();
    bus_write(2'd1, 8'h00);
    bus_write(2'd0, 8'h0A);
    idle(3);
    pulses(3);
    bus_write(2'd0, 8'h00);
    expect_reg("R3 rising edges", 2'd2, 3);
    bus_write(2'd0, 8'h0E);
    idle(3);
    pulses(3);
    bus_write(2'd0, 8'h00);
    expect_reg("R3 falling edges", 2'd2, 6);
  endtask

  task automatic t_gated();
    bus_write(2'd1, 8'h00);
    bus_write(2'd0, 8'h0B);
    idle(3);
    pin = 1'b1; idle(6);
    pin = 1'b0; idle(5);
    bus_write(2'd0, 8'h00);
    expect_reg("R4 gated high", 2'd2, 6);
    pin = 1'b1; idle(4);
    bus_write(2'd0, 8'h0F);
    idle(3);
    pin = 1'b0; idle(5);
    pin = 1'b1; idle(5);
    bus_write(2'd0, 8'h00);
    expect_reg("R4 gated low", 2'd2, 11);
    pin = 1'b0; idle(4);
  endtask

  task automatic t_overflow();
    bus_write(2'd1, 8'hFC);
    bus_write(2'd0, 8'h09);
    idle(4);
    bus_write(2'd0, 8'h00);
    expect_reg("R6 reload after wrap", 2'd2, 8'hFD);
    expect_reg("R6 flag set", 2'd3, 1);
    check("R7 irq masked", irq, 0);
    check("R8 one wake with irq disabled", wake_seen, 1);
    bus_write(2'd0, 8'h10);
    check("R7 irq enabled", irq, 1);
    bus_write(2'd0, 8'h19);
    idle(2);
    bus_write(2'd0, 8'h10);
    expect_reg("R6 second wrap", 2'd2, 8'hFC);
    idle(2);
    check("R8 no wake when flag set", wake_seen, 1);
    bus_write(2'd3, 8'h00);
    expect_reg("R9 flag cleared", 2'd3, 0);
    check("R7 irq drops", irq, 0);
    bus_write(2'd3, 8'h01);
    expect_reg("R9 flag set by write", 2'd3, 1);
    bus_write(2'd3, 8'h00);
  endtask

  task automatic t_collision();
    bus_write(2'd1, 8'hFE);
    bus_write(2'd0, 8'h09);
    idle(1);
    bus_write(2'd3, 8'h00);
    bus_write(2'd0, 8'h00);
    expect_reg("R9 wrap beats clear", 2'd3, 1);
    expect_reg("R6 count after collision", 2'd2, 8'hFF);
    idle(2);
    check("R8 wake on collision wrap", wake_seen, 2);
  endtask

  initial begin
    t_reset();
    t_timer();
    t_mode_zero();
    t_inhibit();
    t_reload_enabled();
    t_event();
    t_gated();
    t_overflow();
    t_collision();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule